// File: doc/BRIEF.md
# Channel-Gain List Scanner

The scanner steers a multiplexed converter front end through a programmable sequence of conversions. A small host-written table holds up to eight entries. Each entry pairs an analog channel code with a gain code for a programmable amplifier, so a sweep can visit channels in any order, revisit a fast channel several times, and give every entry its own gain. Two fixed sweeps need no table: one counts upward over the lowest channels, the other over the highest.

An external pacer pulses `soc_i` when a conversion begins. On that pulse the scanner records the channel and gain that the starting conversion was set up with. It then steps its pointer, so the select outputs show the next entry at once. The multiplexer and amplifier therefore settle while the current conversion is still running. When the converter reports `eoc_i` with its data, the scanner returns the data together with the channel and gain recorded at that conversion's start. The pointer runs from 0 to a programmable last index and then wraps back to 0. While scanning is off, the pointer is held at 0 and the table may be rewritten.

Top module: `chan_gain_scanner`

## Requirements
- R1: After reset the pointer is 0, every table entry is channel 0 and gain 0, `res_valid_o` is 0, and `mux_chan_o`/`pga_gain_o` read 0/0.
- R2: A table write (`wr_en_i`) stores `wr_chan_i`/`wr_gain_i` at `wr_addr_i` only in a cycle where `scan_en_i` is 0; writes presented while `scan_en_i` is 1 change nothing.
- R3: In table mode (`mode_i` = 0, and also 3), `mux_chan_o` and `pga_gain_o` show the channel and gain of the table entry the pointer selects, in the same cycle.
- R4: In a cycle with `scan_en_i` = 1, a high `soc_i` advances the pointer by one at that clock edge, so the select outputs show the next entry in the following cycle; without `soc_i` the pointer holds.
- R5: When `soc_i` arrives with the pointer at or above `last_idx_i`, the pointer returns to 0.
- R6: While `scan_en_i` is 0 the pointer is forced to 0 and `soc_i` has no effect, neither on the pointer nor on the tag that is captured.
- R7: In low sweep mode (`mode_i` = 1) the channel equals the pointer, and the gain is 0.
- R8: In high sweep mode (`mode_i` = 2) the channel equals 2^CH_W - 1 - `last_idx_i` + pointer, and the gain is 0. The sweep covers the top `last_idx_i`+1 channels in ascending order.
- R9: A high `eoc_i` produces a one-cycle `res_valid_o` in the next cycle. It carries `data_i` and the channel and gain that were on the select outputs at the most recent accepted `soc_i`. If `eoc_i` and `soc_i` coincide, the result takes the tag from before that edge.
- R10: Table entries may repeat channels. The list 2,7,2,5 with last index 3 visits channel 2 on every other conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | Scanning enable; blocks table writes |
| mode_i | input | 2 | 0/3 table, 1 low sweep, 2 high sweep |
| last_idx_i | input | PTR_W | Index of the last active entry |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | PTR_W | Table write address |
| wr_chan_i | input | CH_W | Channel code to store |
| wr_gain_i | input | GAIN_W | Gain code to store |
| soc_i | input | 1 | Start-of-conversion pulse |
| eoc_i | input | 1 | End-of-conversion, data valid |
| data_i | input | DATA_W | Converter result |
| mux_chan_o | output | CH_W | Channel select for the next conversion |
| pga_gain_o | output | GAIN_W | Gain select for the next conversion |
| res_valid_o | output | 1 | Tagged result valid |
| res_data_o | output | DATA_W | Result data |
| res_chan_o | output | CH_W | Channel the result was taken on |
| res_gain_o | output | GAIN_W | Gain the result was taken with |

## Verification
The bench targets the wrap point. A design that compares against the entry count instead of the last index would stretch or shorten the sweep by one entry. It also targets an end-of-conversion that lands on the same edge as a start. A tagger that updates its in-flight register first would label the result with the following channel. Table writes made while scanning are issued and then read back through the select outputs after scanning stops; a missing gate would show the overwritten entry. Start pulses are sent while scanning is disabled, to catch a pointer that drifts away from entry 0. The high sweep is exercised with several last indices, to catch off-by-one errors in the base channel.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  typedef enum logic [1:0] {
    SEL_LIST  = 2'd0,
    SEL_LOW   = 2'd1,
    SEL_HIGH  = 2'd2,
    SEL_LIST2 = 2'd3
  } sel_mode_e;
endpackage

// File: rtl/scan_list_mem.sv
module scan_list_mem #(
  parameter int DEPTH  = 8,
  parameter int CH_W   = 4,
  parameter int GAIN_W = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ENT_W = CH_W + GAIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [CH_W-1:0]   wchan_i,
  input  logic [GAIN_W-1:0] wgain_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [CH_W-1:0]   rchan_o,
  output logic [GAIN_W-1:0] rgain_o
);
  logic [DEPTH-1:0][ENT_W-1:0] ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (waddr_i == PTR_W'(i)) ent_q[i] <= {wchan_i, wgain_i};
      end
    end
  end

  assign {rchan_o, rgain_o} = ent_q[raddr_i];
endmodule

// File: rtl/scan_ptr.sv
module scan_ptr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             adv_i,
  input  logic [PTR_W-1:0] last_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (!en_i)   ptr_o <= '0;
    else if (adv_i)   ptr_o <= (ptr_o >= last_i) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/scan_sel.sv
module scan_sel
  import cgs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CH_W   = 4,
  parameter int GAIN_W = 2,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  sel_mode_e         mode_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [PTR_W-1:0]  last_i,
  input  logic [CH_W-1:0]   list_chan_i,
  input  logic [GAIN_W-1:0] list_gain_i,
  output logic [CH_W-1:0]   chan_o,
  output logic [GAIN_W-1:0] gain_o
);
  logic [CH_W-1:0] high_base;
  // top of range minus span: first channel of the high sweep
  assign high_base = {CH_W{1'b1}} - CH_W'(last_i);

  always_comb begin
    unique case (mode_i)
      SEL_LOW: begin
        chan_o = CH_W'(ptr_i);
        gain_o = '0;
      end
      SEL_HIGH: begin
        chan_o = high_base + CH_W'(ptr_i);
        gain_o = '0;
      end
      default: begin
        chan_o = list_chan_i;
        gain_o = list_gain_i;
      end
    endcase
  end
endmodule

// File: rtl/scan_tag.sv
module scan_tag #(
  parameter int CH_W   = 4,
  parameter int GAIN_W = 2,
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [CH_W-1:0]   cur_chan_i,
  input  logic [GAIN_W-1:0] cur_gain_i,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic [CH_W-1:0]   res_chan_o,
  output logic [GAIN_W-1:0] res_gain_o
);
  logic [CH_W-1:0]   fly_chan_q;
  logic [GAIN_W-1:0] fly_gain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fly_chan_q <= '0;
      fly_gain_q <= '0;
    end else if (take_i) begin
      fly_chan_q <= cur_chan_i;
      fly_gain_q <= cur_gain_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_chan_o  <= '0;
      res_gain_o  <= '0;
    end else begin
      res_valid_o <= eoc_i;
      if (eoc_i) begin
        res_data_o <= data_i;
        res_chan_o <= fly_chan_q;
        res_gain_o <= fly_gain_q;
      end
    end
  end
endmodule

// File: rtl/chan_gain_scanner.sv
module chan_gain_scanner
  import cgs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CH_W   = 4,
  parameter int GAIN_W = 2,
  parameter int DATA_W = 12,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_en_i,
  input  logic [1:0]        mode_i,
  input  logic [PTR_W-1:0]  last_idx_i,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_addr_i,
  input  logic [CH_W-1:0]   wr_chan_i,
  input  logic [GAIN_W-1:0] wr_gain_i,
  input  logic              soc_i,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CH_W-1:0]   mux_chan_o,
  output logic [GAIN_W-1:0] pga_gain_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic [CH_W-1:0]   res_chan_o,
  output logic [GAIN_W-1:0] res_gain_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic [CH_W-1:0]   list_chan;
  logic [GAIN_W-1:0] list_gain;
  logic              take;

  assign take = scan_en_i & soc_i;

  scan_list_mem #(.DEPTH(DEPTH), .CH_W(CH_W), .GAIN_W(GAIN_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i & ~scan_en_i),
    .waddr_i (wr_addr_i),
    .wchan_i (wr_chan_i),
    .wgain_i (wr_gain_i),
    .raddr_i (ptr_q),
    .rchan_o (list_chan),
    .rgain_o (list_gain)
  );

  scan_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (scan_en_i),
    .adv_i  (soc_i),
    .last_i (last_idx_i),
    .ptr_o  (ptr_q)
  );

  scan_sel #(.DEPTH(DEPTH), .CH_W(CH_W), .GAIN_W(GAIN_W)) u_sel (
    .mode_i      (sel_mode_e'(mode_i)),
    .ptr_i       (ptr_q),
    .last_i      (last_idx_i),
    .list_chan_i (list_chan),
    .list_gain_i (list_gain),
    .chan_o      (mux_chan_o),
    .gain_o      (pga_gain_o)
  );

  scan_tag #(.CH_W(CH_W), .GAIN_W(GAIN_W), .DATA_W(DATA_W)) u_tag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .cur_chan_i  (mux_chan_o),
    .cur_gain_i  (pga_gain_o),
    .eoc_i       (eoc_i),
    .data_i      (data_i),
    .res_valid_o (res_valid_o),
    .res_data_o  (res_data_o),
    .res_chan_o  (res_chan_o),
    .res_gain_o  (res_gain_o)
  );
endmodule

// File: rtl/chan_gain_scanner_chk.sv
module chan_gain_scanner_chk #(
  parameter int DEPTH  = 8,
  parameter int CH_W   = 4,
  parameter int GAIN_W = 2,
  parameter int DATA_W = 12,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scan_en_i,
  input logic              soc_i,
  input logic              eoc_i,
  input logic [PTR_W-1:0]  last_idx_i,
  input logic [DATA_W-1:0] data_i,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [CH_W-1:0]   mux_chan_o,
  input logic [GAIN_W-1:0] pga_gain_o,
  input logic              res_valid_o,
  input logic [DATA_W-1:0] res_data_o,
  input logic [CH_W-1:0]   res_chan_o,
  input logic [GAIN_W-1:0] res_gain_o
);
  a_r6_ptr_zero_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |=> ptr_q == '0);

  a_r4_hold_without_soc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i && !soc_i) |=> $stable(ptr_q));

  a_r4_step_on_soc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i && soc_i && ptr_q < last_idx_i) |=> ptr_q == $past(ptr_q) + 1'b1);

  a_r5_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i && soc_i && ptr_q >= last_idx_i) |=> ptr_q == '0);

  a_r9_result_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |=> (res_valid_o && res_data_o == $past(data_i)));

  a_r9_no_spurious_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_i |=> !res_valid_o);

  a_r9_tag_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i && soc_i && !eoc_i) ##1 (eoc_i && !(scan_en_i && soc_i))
      |=> (res_chan_o == $past(mux_chan_o, 2) && res_gain_o == $past(pga_gain_o, 2)));
endmodule

bind chan_gain_scanner chan_gain_scanner_chk #(
  .DEPTH(DEPTH), .CH_W(CH_W), .GAIN_W(GAIN_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/chan_gain_scanner_tb_top.sv
`timescale 1ns/1ps
module chan_gain_scanner_tb_top;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic scan_en, wr_en, soc, eoc;
  logic [1:0]  mode;
  logic [2:0]  last_idx, wr_addr;
  logic [3:0]  wr_chan;
  logic [1:0]  wr_gain;
  logic [11:0] data;
  logic [3:0]  mux_chan, res_chan;
  logic [1:0]  pga_gain, res_gain;
  logic        res_valid;
  logic [11:0] res_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  logic [3:0]  m_chan [8];
  logic [1:0]  m_gain [8];
  logic [2:0]  m_ptr;
  logic [3:0]  m_fc, m_rc;
  logic [1:0]  m_fg, m_rg;
  logic        m_rv;
  logic [11:0] m_rd;

  always #(CLK_NS/2) clk = ~clk;

  chan_gain_scanner dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scan_en_i(scan_en), .mode_i(mode),
    .last_idx_i(last_idx), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_chan_i(wr_chan), .wr_gain_i(wr_gain), .soc_i(soc), .eoc_i(eoc),
    .data_i(data), .mux_chan_o(mux_chan), .pga_gain_o(pga_gain),
    .res_valid_o(res_valid), .res_data_o(res_data), .res_chan_o(res_chan),
    .res_gain_o(res_gain)
  );

  function automatic logic [3:0] f_chan(input logic [1:0] md, input logic [2:0] p, input logic [2:0] l);
    case (md)
      2'd1:    return 4'(p);
      2'd2:    return 4'(15 - int'(l) + int'(p));
      default: return m_chan[p];
    endcase
  endfunction

  function automatic logic [1:0] f_gain(input logic [1:0] md, input logic [2:0] p);
    return (md == 2'd1 || md == 2'd2) ? 2'd0 : m_gain[p];
  endfunction

  function automatic string f_req(input logic [1:0] md);
    return (md == 2'd1) ? "R7" : (md == 2'd2) ? "R8" : "R3";
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(f_req(mode), mux_chan, f_chan(mode, m_ptr, last_idx));
    check(f_req(mode), pga_gain, f_gain(mode, m_ptr));
    check("R9", res_valid, m_rv);
    if (m_rv) begin
      check("R9", res_data, m_rd);
      check("R9", res_chan, m_rc);
      check("R9", res_gain, m_rg);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    m_rv = eoc;
    if (eoc) begin m_rd = data; m_rc = m_fc; m_rg = m_fg; end
    if (scan_en && soc) begin
      m_fc = f_chan(mode, m_ptr, last_idx);
      m_fg = f_gain(mode, m_ptr);
    end
    if (wr_en && !scan_en) begin m_chan[wr_addr] = wr_chan; m_gain[wr_addr] = wr_gain; end
    if (!scan_en) m_ptr = 3'd0;
    else if (soc) m_ptr = (m_ptr >= last_idx) ? 3'd0 : m_ptr + 3'd1;
    #2;
    compare_all();
  endtask

  task automatic host_write(input logic [2:0] a, input logic [3:0] c, input logic [1:0] g);
    wr_en = 1; wr_addr = a; wr_chan = c; wr_gain = g;
    tick();
    wr_en = 0;
  endtask

  task automatic pulse_soc();
    soc = 1; tick(); soc = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5CA7;
    void'($urandom(seed));
    rst_n = 0; scan_en = 0; wr_en = 0; soc = 0; eoc = 0; mode = 0;
    last_idx = 3'd7; wr_addr = 0; wr_chan = 0; wr_gain = 0; data = 0;
    for (int i = 0; i < 8; i++) begin m_chan[i] = 0; m_gain[i] = 0; end
    m_ptr = 0; m_fc = 0; m_fg = 0; m_rv = 0; m_rd = 0; m_rc = 0; m_rg = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    check("R1", mux_chan, 0); check("R1", pga_gain, 0); check("R1", res_valid, 0);

    // R10 repeated-channel list 2,7,2,5
    host_write(3'd0, 4'd2, 2'd1);
    host_write(3'd1, 4'd7, 2'd3);
    host_write(3'd2, 4'd2, 2'd0);
    host_write(3'd3, 4'd5, 2'd2);
    last_idx = 3'd3;
    tick();
    check("R3", mux_chan, 2); check("R3", pga_gain, 1);
    scan_en = 1; tick();
    repeat (3) tick();
    check("R4", mux_chan, 2);                 // no soc: holds
    pulse_soc(); check("R10", mux_chan, 7); check("R4", pga_gain, 3);
    pulse_soc(); check("R10", mux_chan, 2);
    pulse_soc(); check("R10", mux_chan, 5);
    pulse_soc(); check("R5", mux_chan, 2); check("R5", pga_gain, 1);

    // R9 tag: started on channel 2 gain 1
    pulse_soc();                              // conversion on ch2/g1 begins, now shows 7
    eoc = 1; data = 12'hABC; tick(); eoc = 0;
    check("R9", res_valid, 1); check("R9", res_chan, 2);
    check("R9", res_gain, 1); check("R9", res_data, 12'hABC);
    tick(); check("R9", res_valid, 0);
    // coincident soc and eoc: result keeps the earlier tag (ch7/g3)
    soc = 1; tick();                          // starts ch7, shows 2
    eoc = 1; data = 12'h123; tick(); soc = 0; eoc = 0;
    check("R9", res_chan, 7); check("R9", res_gain, 3);

    // R2 write while scanning ignored
    wr_en = 1; wr_addr = 3'd0; wr_chan = 4'd9; wr_gain = 2'd2; tick(); wr_en = 0;
    scan_en = 0; tick();
    check("R2", mux_chan, 2); check("R2", pga_gain, 1);
    // R6 soc ignored while disabled
    pulse_soc(); pulse_soc();
    check("R6", mux_chan, 2);

    // R7 low sweep, last index 5
    mode = 2'd1; last_idx = 3'd5; scan_en = 1; tick();
    check("R7", mux_chan, 0);
    for (int i = 1; i <= 6; i++) begin
      pulse_soc();
      check("R7", mux_chan, i % 6); check("R7", pga_gain, 0);
    end
    // R8 high sweep, last index 2: 13,14,15,13
    scan_en = 0; tick();
    mode = 2'd2; last_idx = 3'd2; scan_en = 1; tick();
    check("R8", mux_chan, 13);
    pulse_soc(); check("R8", mux_chan, 14);
    pulse_soc(); check("R8", mux_chan, 15);
    pulse_soc(); check("R8", mux_chan, 13);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 99) < 3) scan_en = ~scan_en;
      if ($urandom_range(0, 99) < 2) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) < 2) last_idx = 3'($urandom_range(0, 7));
      wr_en   = ($urandom_range(0, 99) < 20);
      wr_addr = 3'($urandom); wr_chan = 4'($urandom); wr_gain = 2'($urandom);
      soc     = ($urandom_range(0, 99) < 35);
      eoc     = ($urandom_range(0, 99) < 35);
      data    = 12'($urandom);
      tick();
    end
    soc = 0; eoc = 0; wr_en = 0;
    tick();

    done = 1;
    summary();
    $finish;
  end
endmodule